// File: doc/BRIEF.md
# Nametable Source Selector with Fill and Extended-Attribute Modes

This block sits between the picture unit's nametable port and the memories behind it. The 12-bit video address spans four 1 KB pages, and the top two bits pick the page. A page-map register says where each page's accesses go. Each page can go to one of two pages of external video RAM, to a 1 KB extension RAM held inside the block, or to a fill generator. The fill generator has no storage. It returns a programmed tile byte for the tile area of the page and a programmed attribute byte for the attribute area, which starts at page offset 0x3C0.

A second mode is the extended-attribute mode. In this mode every tile fetch from an external page also reads the extension RAM at the same offset. From that byte the block latches a per-tile character bank and a palette. The next attribute fetch from an external page returns the latched palette in place of memory data. A peek input marks a debug read. A peek read returns the normal data but does not update either latch.

Reads are answered one cycle after the request by a small response state machine. The state machine has six states:
- `ST_IDLE`: no response is due.
- `ST_HOLD`: returns a byte captured at request time, either the fill tile, the fill attribute or the blocked value 0x00.
- `ST_EXT`: returns the extension RAM output.
- `ST_VRAM`: returns the external RAM data.
- `ST_XTILE`: returns the external RAM data and latches the bank and palette.
- `ST_XATTR`: returns the latched attribute.

The machine enters `ST_HOLD`, `ST_EXT`, `ST_VRAM`, `ST_XTILE` or `ST_XATTR` from any state when a read is requested. It goes to `ST_IDLE` when no read is requested.

Top module: `nt_page_router`

## Requirements
- R1: Configuration register 0 is the page map. Page p (video address bits 11..10) uses map bits 2p+1..2p. Code 0 selects external RAM page 0 and code 1 selects external RAM page 1. A read on such a page asserts `vram_rd` with `vram_page` equal to the code's low bit and `vram_addr` equal to the page offset. The returned data is `vram_rdata`.
- R2: On a fill page (code 3), a read at page offset 0x3C0 or above returns the fill attribute byte. Any lower offset returns the fill tile byte (configuration register 1).
- R3: A write to configuration register 2 stores its low 2 bits replicated into all four 2-bit positions of the fill attribute byte.
- R4: On an extension page (code 2), a read returns the extension RAM byte at the page offset while bit 1 of the extension control (configuration register 3) is 0. When that bit is 1, the read returns 0x00.
- R5: A write to an extension page stores the byte in the extension RAM. A write to an external page asserts `vram_wr` with that page's select, offset and data. A write to a fill page is discarded, and `vram_wr` stays low.
- R6: When the extension control equals 1, a non-peek read below offset 0x3C0 on an external page returns the external data. Two cycles after the request, `chr_bank` shows {upper character register, extension RAM bits 5..0 at that offset}.
- R7: That same fetch latches extension RAM bits 7..6, replicated four times, as `ext_attr`. Later attribute reads (offset 0x3C0 and above) on external pages return it without asserting `vram_rd`. This holds even when the attribute read directly follows the tile read.
- R8: The extension control (register 3) and the upper character register (register 4) keep only the low 2 bits of the written byte.
- R9: A read with `vid_peek` high changes neither `chr_bank` nor `ext_attr`.
- R10: After reset, `vid_rvalid`, `chr_bank` and `ext_attr` are 0, and all four pages map to external page 0.
- R11: `vid_rvalid` is high in exactly the cycle after a read request (`vid_rd` high, `vid_wr` low). If both `vid_rd` and `vid_wr` are high, the write takes place and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 3 | Configuration register select (0 map, 1 fill tile, 2 fill palette, 3 extension control, 4 upper character) |
| cfg_wdata | input | 8 | Configuration write data |
| vid_rd | input | 1 | Video read request |
| vid_wr | input | 1 | Video write request |
| vid_peek | input | 1 | Read is a debug peek; no latching |
| vid_addr | input | 12 | Video address: page in 11..10, offset in 9..0 |
| vid_wdata | input | 8 | Video write data |
| vid_rvalid | output | 1 | Read data valid, one cycle after the request |
| vid_rdata | output | 8 | Read data |
| vram_rd | output | 1 | External RAM read strobe |
| vram_wr | output | 1 | External RAM write strobe |
| vram_page | output | 1 | External RAM page select |
| vram_addr | output | 10 | External RAM offset |
| vram_wdata | output | 8 | External RAM write data |
| vram_rdata | input | 8 | External RAM read data, valid one cycle after `vram_rd` |
| chr_bank | output | 8 | Latched per-tile character bank |
| ext_attr | output | 8 | Latched replicated attribute byte |

## Verification
Strobes and address on the external RAM side are combinational, so they are checked within the request cycle, a moment after the inputs are driven. Read data and `vid_rvalid` come from the registered response state, so they are checked at the falling edge after the next rising edge. The bank and attribute latches load on the edge that ends the response cycle, so they are checked one falling edge later again. The bench drives all inputs at falling edges, which keeps each check aligned with its due cycle. For the back-to-back attribute case, the second request is issued in the response cycle of the first.

// File: rtl/nt_pkg.sv
package nt_pkg;

    typedef enum logic [1:0] {
        SRC_VRAM0 = 2'd0,
        SRC_VRAM1 = 2'd1,
        SRC_EXT   = 2'd2,
        SRC_FILL  = 2'd3
    } nt_src_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_EXT   = 3'd2,
        ST_VRAM  = 3'd3,
        ST_XTILE = 3'd4,
        ST_XATTR = 3'd5
    } resp_state_e;

    localparam logic [2:0] CFG_MAP   = 3'd0;
    localparam logic [2:0] CFG_FTILE = 3'd1;
    localparam logic [2:0] CFG_FPAL  = 3'd2;
    localparam logic [2:0] CFG_XCTL  = 3'd3;
    localparam logic [2:0] CFG_UPPER = 3'd4;

    localparam logic [1:0] XCTL_EXTATTR = 2'd1;

endpackage

// File: rtl/nt_cfg_regs.sv
module nt_cfg_regs
    import nt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAGES  = 4,
    parameter int CFG_AW = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [DATA_W-1:0]      cfg_wdata,
    output nt_src_e [PAGES-1:0]    page_src,
    output logic [DATA_W-1:0]      fill_tile,
    output logic [DATA_W-1:0]      fill_attr,
    output logic [1:0]             xctl,
    output logic [1:0]             upper_chr
);
    localparam int FIELD_W = 2;
    localparam int MAP_W   = PAGES * FIELD_W;
    localparam int REP     = DATA_W / FIELD_W;

    logic [MAP_W-1:0]  map_q;
    logic [DATA_W-1:0] ftile_q;
    logic [DATA_W-1:0] fattr_q;
    logic [1:0]        xctl_q;
    logic [1:0]        upper_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q   <= '0;
            ftile_q <= '0;
            fattr_q <= '0;
            xctl_q  <= '0;
            upper_q <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                CFG_MAP:   map_q   <= cfg_wdata[MAP_W-1:0];
                CFG_FTILE: ftile_q <= cfg_wdata;
                CFG_FPAL:  fattr_q <= {REP{cfg_wdata[1:0]}};
                CFG_XCTL:  xctl_q  <= cfg_wdata[1:0];
                CFG_UPPER: upper_q <= cfg_wdata[1:0];
                default:   ;
            endcase
        end
    end

    for (genvar p = 0; p < PAGES; p++) begin : g_page_field
        assign page_src[p] = nt_src_e'(map_q[FIELD_W*p +: FIELD_W]);
    end

    assign fill_tile = ftile_q;
    assign fill_attr = fattr_q;
    assign xctl      = xctl_q;
    assign upper_chr = upper_q;

    // R3: palette replicated into every 2-bit position
    assert_fill_replicated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CFG_FPAL) |=> (fattr_q == {REP{$past(cfg_wdata[1:0])}}));

endmodule

// File: rtl/nt_exram.sv
module nt_exram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/nt_resp_fsm.sv
module nt_resp_fsm
    import nt_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int UPPER_W = 2,
    localparam int LOW_W  = 6,
    localparam int BANK_W = UPPER_W + LOW_W,
    localparam int REP    = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_peek,
    input  nt_src_e           req_src,
    input  logic              req_attr,
    input  logic [1:0]        xctl,
    input  logic [UPPER_W-1:0] upper_chr,
    input  logic [DATA_W-1:0] fill_tile,
    input  logic [DATA_W-1:0] fill_attr,
    input  logic [DATA_W-1:0] exram_q,
    input  logic [DATA_W-1:0] vram_rdata,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic [BANK_W-1:0] chr_bank,
    output logic [DATA_W-1:0] ext_attr
);
    resp_state_e       state_q, state_d;
    logic [DATA_W-1:0] hold_q, hold_d;
    logic [BANK_W-1:0] bank_q;
    logic [DATA_W-1:0] xattr_q;
    logic              ext_mode;

    assign ext_mode = (xctl == XCTL_EXTATTR);

    always_comb begin
        state_d = ST_IDLE;
        hold_d  = hold_q;
        if (req_rd) begin
            unique case (req_src)
                SRC_FILL: begin
                    state_d = ST_HOLD;
                    hold_d  = req_attr ? fill_attr : fill_tile;
                end
                SRC_EXT: begin
                    if (xctl[1]) begin
                        state_d = ST_HOLD;
                        hold_d  = '0;
                    end else begin
                        state_d = ST_EXT;
                    end
                end
                SRC_VRAM0, SRC_VRAM1: begin
                    if (ext_mode && req_attr) begin
                        state_d = ST_XATTR;
                    end else if (ext_mode && !req_peek) begin
                        state_d = ST_XTILE;
                    end else begin
                        state_d = ST_VRAM;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q  <= '0;
            xattr_q <= '0;
        end else if (state_q == ST_XTILE) begin
            bank_q  <= {upper_chr, exram_q[LOW_W-1:0]};
            xattr_q <= {REP{exram_q[DATA_W-1 -: 2]}};
        end
    end

    always_comb begin
        rvalid = 1'b1;
        rdata  = '0;
        unique case (state_q)
            ST_IDLE:  rvalid = 1'b0;
            ST_HOLD:  rdata  = hold_q;
            ST_EXT:   rdata  = exram_q;
            ST_VRAM:  rdata  = vram_rdata;
            ST_XTILE: rdata  = vram_rdata;
            ST_XATTR: rdata  = xattr_q;
            default:  rvalid = 1'b0;
        endcase
    end

    assign chr_bank = bank_q;
    assign ext_attr = xattr_q;

    // R9: a peek read leaves the latches untouched once its response has passed
    assert_peek_no_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && req_peek) |=> ##1 ($stable(bank_q) && $stable(xattr_q)));

endmodule

// File: rtl/nt_page_router.sv
module nt_page_router
    import nt_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int OFS_W     = 10,
    parameter int UPPER_W   = 2,
    parameter int ATTR_BASE = 960,
    localparam int PAGE_W   = ADDR_W - OFS_W,
    localparam int PAGES    = 1 << PAGE_W,
    localparam int DEPTH    = 1 << OFS_W,
    localparam int BANK_W   = UPPER_W + 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              vid_rd,
    input  logic              vid_wr,
    input  logic              vid_peek,
    input  logic [ADDR_W-1:0] vid_addr,
    input  logic [DATA_W-1:0] vid_wdata,
    output logic              vid_rvalid,
    output logic [DATA_W-1:0] vid_rdata,
    output logic              vram_rd,
    output logic              vram_wr,
    output logic              vram_page,
    output logic [OFS_W-1:0]  vram_addr,
    output logic [DATA_W-1:0] vram_wdata,
    input  logic [DATA_W-1:0] vram_rdata,
    output logic [BANK_W-1:0] chr_bank,
    output logic [DATA_W-1:0] ext_attr
);
    nt_src_e [PAGES-1:0] page_src;
    logic [DATA_W-1:0]   fill_tile, fill_attr, exram_q;
    logic [1:0]          xctl;
    logic [UPPER_W-1:0]  upper_chr;
    logic [PAGE_W-1:0]   page_idx;
    logic [OFS_W-1:0]    ofs;
    nt_src_e             cur_src;
    logic                is_attr, is_internal, rd_ok;

    assign page_idx    = vid_addr[ADDR_W-1 -: PAGE_W];
    assign ofs         = vid_addr[OFS_W-1:0];
    assign cur_src     = page_src[page_idx];
    assign is_attr     = (ofs >= OFS_W'(ATTR_BASE));
    assign is_internal = (cur_src == SRC_VRAM0) || (cur_src == SRC_VRAM1);
    assign rd_ok       = vid_rd && !vid_wr;

    nt_cfg_regs #(.DATA_W(DATA_W), .PAGES(PAGES), .CFG_AW(3)) i_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .page_src(page_src), .fill_tile(fill_tile),
        .fill_attr(fill_attr), .xctl(xctl), .upper_chr(upper_chr)
    );

    nt_exram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_exram (
        .clk(clk),
        .we(vid_wr && cur_src == SRC_EXT),
        .re(rd_ok),
        .addr(ofs),
        .wdata(vid_wdata),
        .rdata(exram_q)
    );

    nt_resp_fsm #(.DATA_W(DATA_W), .UPPER_W(UPPER_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .req_rd(rd_ok), .req_peek(vid_peek),
        .req_src(cur_src), .req_attr(is_attr), .xctl(xctl),
        .upper_chr(upper_chr), .fill_tile(fill_tile), .fill_attr(fill_attr),
        .exram_q(exram_q), .vram_rdata(vram_rdata), .rvalid(vid_rvalid),
        .rdata(vid_rdata), .chr_bank(chr_bank), .ext_attr(ext_attr)
    );

    assign vram_rd    = rd_ok && is_internal && !(xctl == XCTL_EXTATTR && is_attr);
    assign vram_wr    = vid_wr && is_internal;
    assign vram_page  = cur_src[0];
    assign vram_addr  = ofs;
    assign vram_wdata = vid_wdata;

    // R11: a response follows every accepted read request, one cycle later
    assert_rvalid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |=> vid_rvalid);

    assert_rvalid_only_after_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |=> !vid_rvalid);

    // R4: a blocked extension page returns zero
    assert_ext_blocked_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && cur_src == SRC_EXT && xctl[1]) |=> (vid_rdata == '0));

    // R2: fill attribute area returns the fill attribute byte
    assert_fill_attr_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && cur_src == SRC_FILL && is_attr) |=> (vid_rdata == $past(fill_attr)));

endmodule

// File: tb/test_nt_page_router.sv
`timescale 1ns/1ps
module test_nt_page_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        vid_rd = 1'b0, vid_wr = 1'b0, vid_peek = 1'b0;
    logic [11:0] vid_addr = '0;
    logic [7:0]  vid_wdata = '0;
    logic        vid_rvalid;
    logic [7:0]  vid_rdata;
    logic        vram_rd, vram_wr, vram_page;
    logic [9:0]  vram_addr;
    logic [7:0]  vram_wdata;
    logic [7:0]  vram_rdata = '0;
    logic [7:0]  chr_bank, ext_attr;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic req_vram_rd, req_vram_page;

    always #2.5 clk = ~clk;

    nt_page_router i_nt_page_router (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .vid_rd(vid_rd), .vid_wr(vid_wr),
        .vid_peek(vid_peek), .vid_addr(vid_addr), .vid_wdata(vid_wdata),
        .vid_rvalid(vid_rvalid), .vid_rdata(vid_rdata), .vram_rd(vram_rd),
        .vram_wr(vram_wr), .vram_page(vram_page), .vram_addr(vram_addr),
        .vram_wdata(vram_wdata), .vram_rdata(vram_rdata),
        .chr_bank(chr_bank), .ext_attr(ext_attr)
    );

    function automatic logic [7:0] vmodel(input logic pg, input logic [9:0] a);
        return a[7:0] ^ {a[9:8], 6'b0} ^ (pg ? 8'hA5 : 8'h00);
    endfunction

    // external RAM model: one-cycle read latency
    always @(posedge clk) begin
        if (vram_rd) vram_rdata <= vmodel(vram_page, vram_addr);
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic vid_read(input logic [11:0] a, input logic peek, output logic [7:0] d);
        @(negedge clk);
        vid_rd = 1'b1; vid_addr = a; vid_peek = peek;
        #1;
        req_vram_rd = vram_rd; req_vram_page = vram_page;
        @(negedge clk);
        check("R11 rvalid in response cycle", {15'b0, vid_rvalid}, 16'd1);
        d = vid_rdata;
        vid_rd = 1'b0; vid_peek = 1'b0;
    endtask

    task automatic vid_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        vid_wr = 1'b1; vid_addr = a; vid_wdata = d;
        @(negedge clk);
        vid_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 rvalid after reset", {15'b0, vid_rvalid}, 16'd0);
        check("R10 chr_bank after reset", {8'b0, chr_bank}, 16'h0);
        check("R10 ext_attr after reset", {8'b0, ext_attr}, 16'h0);
        @(negedge clk);
        vid_rd = 1'b1; vid_addr = 12'hC21;
        #1;
        check("R10 page 3 maps to external page 0", {14'b0, vram_rd, vram_page}, 16'b10);
        @(negedge clk);
        vid_rd = 1'b0;
        check("R10 read data from page 0", {8'b0, vid_rdata}, {8'b0, vmodel(1'b0, 10'h021)});
        @(negedge clk);
        check("R11 rvalid drops after response", {15'b0, vid_rvalid}, 16'd0);
    endtask

    task automatic t_internal();
        logic [7:0] d;
        cfg_write(3'd0, 8'hE4);
        vid_read(12'h455, 1'b0, d);
        check("R1 page1 strobe and select", {14'b0, req_vram_rd, req_vram_page}, 16'b11);
        check("R1 page1 data", {8'b0, d}, {8'b0, vmodel(1'b1, 10'h055)});
        vid_read(12'h2AA, 1'b0, d);
        check("R1 page0 select", {14'b0, req_vram_rd, req_vram_page}, 16'b10);
        check("R1 page0 data", {8'b0, d}, {8'b0, vmodel(1'b0, 10'h2AA)});
    endtask

    task automatic t_fill();
        logic [7:0] d;
        cfg_write(3'd1, 8'h3C);
        cfg_write(3'd2, 8'hFE);
        vid_read(12'hC10, 1'b0, d);
        check("R2 fill tile byte", {8'b0, d}, 16'h3C);
        check("R2 fill read no vram strobe", {15'b0, req_vram_rd}, 16'd0);
        vid_read(12'hFBF, 1'b0, d);
        check("R2 offset 0x3BF is tile", {8'b0, d}, 16'h3C);
        vid_read(12'hFC0, 1'b0, d);
        check("R3 fill attr replicated", {8'b0, d}, 16'hAA);
        vid_read(12'hFFF, 1'b0, d);
        check("R2 last offset is attr", {8'b0, d}, 16'hAA);
    endtask

    task automatic t_writes();
        logic [7:0] d;
        vid_write(12'h805, 8'h9B);
        vid_read(12'h805, 1'b0, d);
        check("R4 ext page read", {8'b0, d}, 16'h9B);
        cfg_write(3'd3, 8'h02);
        vid_read(12'h805, 1'b0, d);
        check("R4 ext page blocked", {8'b0, d}, 16'h00);
        cfg_write(3'd3, 8'h00);
        @(negedge clk);
        vid_wr = 1'b1; vid_addr = 12'h412; vid_wdata = 8'h77;
        #1;
        check("R5 internal write strobe/page", {14'b0, vram_wr, vram_page}, 16'b11);
        check("R5 internal write addr", {6'b0, vram_addr}, 16'h012);
        check("R5 internal write data", {8'b0, vram_wdata}, 16'h77);
        @(negedge clk);
        vid_wr = 1'b1; vid_addr = 12'hC20; vid_wdata = 8'h11;
        #1;
        check("R5 fill write no strobe", {15'b0, vram_wr}, 16'd0);
        @(negedge clk);
        vid_wr = 1'b0;
        vid_read(12'hC20, 1'b0, d);
        check("R5 fill write discarded", {8'b0, d}, 16'h3C);
        vid_read(12'h805, 1'b0, d);
        check("R5 ext byte kept", {8'b0, d}, 16'h9B);
    endtask

    task automatic t_extattr();
        logic [7:0] d;
        vid_write(12'h810, 8'hC7);
        vid_write(12'h811, 8'h45);
        cfg_write(3'd3, 8'hFD);
        cfg_write(3'd4, 8'hFE);
        vid_read(12'h010, 1'b0, d);
        check("R6 tile read returns vram data", {8'b0, d}, {8'b0, vmodel(1'b0, 10'h010)});
        @(negedge clk);
        check("R8 R6 bank latched", {8'b0, chr_bank}, 16'h87);
        check("R7 attr latched", {8'b0, ext_attr}, 16'hFF);
        vid_read(12'h3C5, 1'b0, d);
        check("R7 attr read returns latch", {8'b0, d}, 16'hFF);
        check("R7 attr read no vram strobe", {15'b0, req_vram_rd}, 16'd0);
        // back-to-back tile then attr
        @(negedge clk);
        vid_rd = 1'b1; vid_addr = 12'h011;
        @(negedge clk);
        check("R6 b2b tile data", {8'b0, vid_rdata}, {8'b0, vmodel(1'b0, 10'h011)});
        vid_addr = 12'h3C0;
        @(negedge clk);
        vid_rd = 1'b0;
        check("R7 b2b attr returns new latch", {8'b0, vid_rdata}, 16'h55);
        check("R6 b2b bank", {8'b0, chr_bank}, 16'h85);
    endtask

    task automatic t_peek();
        logic [7:0] d;
        vid_read(12'h010, 1'b1, d);
        check("R9 peek data", {8'b0, d}, {8'b0, vmodel(1'b0, 10'h010)});
        @(negedge clk);
        @(negedge clk);
        check("R9 bank unchanged", {8'b0, chr_bank}, 16'h85);
        check("R9 attr unchanged", {8'b0, ext_attr}, 16'h55);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_internal();
        t_fill();
        t_writes();
        t_extattr();
        t_peek();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule